// File: doc/BRIEF.md
# Dual-Channel Phase-Offset Conversion Scheduler

This block produces the conversion-complete timing for two converter channels that share one sampling clock. Each channel runs an averaging window of N decimation-clock-enable cycles. Channel 1 is the fixed timing reference. Channel 0's window is shifted against it by a signed 8-bit phase code. For every channel the block emits a window-start strobe, which a downstream averaging filter uses, and a data-ready strobe.

The phase code and the oversampling-ratio selector are written through a simple write strobe. They take effect at the next Channel 1 window boundary. An active-low hard reset holds the whole schedule idle, blocks configuration writes and restores the default settings. After any reset, data-ready strobes are withheld until a settling interval of decimation enables has elapsed. Window-start strobes are not withheld.

Top module: `phase_offset_sched`

## Requirements
- R1: The phase code is an 8-bit two's-complement value in the range -128..+127. Channel 0's window is offset by that code taken modulo the window length N. For example, code 0x80 (-128) with N=256 places Channel 0's strobe 128 enables after Channel 1's strobe.
- R2: For a positive code P, Channel 0's data-ready follows Channel 1's data-ready by exactly P decimation enables, so Channel 0 lags.
- R3: For a negative code -M, Channel 0's data-ready comes M enables before each Channel 1 data-ready (N-M enables after the previous one), so Channel 0 leads.
- R4: The 2-bit ratio selector s sets N = OSR_BASE << s (32, 64, 128 or 256 by default). Channel 1 strobes once every N enables.
- R5: A written phase or ratio takes effect only at the next Channel 1 boundary. At that enable Channel 1 strobes, and Channel 0 restarts its window at offset -P mod N under the new setting.
- R6: Each strobe is registered and one clock wide. It is high in the clock that follows the decimation-enable edge that completes the window.
- R7: While hard_rst_n is low, all four strobes stay low and both window counters are held at zero.
- R8: Writes made while hard_rst_n is low are ignored. The configuration returns to phase 0 with selector 0 (N=32), so after release both channels strobe together.
- R9: After any reset, data-ready is suppressed on the first SETTLE_CYC (default 50) decimation enables. Window-start strobes on those enables still appear.
- R10: The synchronous active-high rst clears the same state as the hard reset, and all outputs read zero while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hard_rst_n | input | 1 | Active-low hard reset, synchronous |
| dclk_en | input | 1 | Decimation-clock enable, one clock per tick |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_phase | input | 8 | Signed phase code to write |
| cfg_osr_sel | input | 2 | Oversampling-ratio selector to write |
| win0 | output | 1 | Channel 0 window-start strobe |
| win1 | output | 1 | Channel 1 window-start strobe |
| drdy0 | output | 1 | Channel 0 data-ready strobe |
| drdy1 | output | 1 | Channel 1 data-ready strobe |

## Verification
Every strobe becomes visible one clock after the decimation-enable edge that closes its window. That edge is identified by its enable index counted from reset release. The bench latches its enable count at each rising edge and samples the outputs at the following falling edge, so every observed strobe is matched against a queued channel and enable index. Configuration writes are placed away from Channel 1 boundaries, so the boundary at which each new setting applies is unambiguous. The enable at which each Channel 0 reload lands is computed from R5.

// File: rtl/pos_pkg.sv
`timescale 1ns/1ps
package pos_pkg;
  localparam int PH_W  = 8;
  localparam int SEL_W = 2;

  typedef logic signed [PH_W-1:0] phase_t;

  typedef struct packed {
    phase_t            phase;
    logic [SEL_W-1:0]  osr_sel;
  } sched_cfg_t;
endpackage

// File: rtl/pos_cfg_regs.sv
`timescale 1ns/1ps
module pos_cfg_regs
  import pos_pkg::*;
#(
  parameter int SEL_DEF = 0
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             wr,
  input  phase_t           wr_phase,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic             bnd,
  output sched_cfg_t       shadow_q,
  output sched_cfg_t       active_q
);
  localparam sched_cfg_t CFG_DEF = '{phase: '0, osr_sel: SEL_W'(SEL_DEF)};

  // pending settings, written at any time outside reset
  always_ff @(posedge clk) begin
    if (clr)     shadow_q <= CFG_DEF;
    else if (wr) shadow_q <= '{phase: wr_phase, osr_sel: wr_sel};
  end

  // applied settings, moved over only at a reference boundary
  always_ff @(posedge clk) begin
    if (clr)      active_q <= CFG_DEF;
    else if (bnd) active_q <= shadow_q;
  end

  a_r8_defaults_after_clear: assert property (@(posedge clk)
    clr |=> (shadow_q == CFG_DEF && active_q == CFG_DEF));

  a_r5_apply_only_at_boundary: assert property (@(posedge clk) disable iff (clr)
    !bnd |=> $stable(active_q));
endmodule

// File: rtl/pos_window_ctr.sv
`timescale 1ns/1ps
module pos_window_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             dclk_en,
  input  logic [CNT_W-1:0] mask,
  input  logic             reload,
  input  logic [CNT_W-1:0] load_val,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] inc;

  assign inc = (cnt_q + CNT_W'(1)) & mask;

  always_comb begin
    if (reload) hit = dclk_en && (load_val == '0);
    else        hit = dclk_en && (inc == '0);
  end

  always_ff @(posedge clk) begin
    if (clr)            cnt_q <= '0;
    else if (dclk_en)   cnt_q <= reload ? load_val : inc;
  end

  a_r7_counter_idle_in_clear: assert property (@(posedge clk)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/pos_settle_ctr.sv
`timescale 1ns/1ps
module pos_settle_ctr #(
  parameter int SETTLE_CYC = 50
) (
  input  logic clk,
  input  logic clr,
  input  logic dclk_en,
  output logic settled
);
  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam logic [SW-1:0] LIM = SW'(SETTLE_CYC);

  logic [SW-1:0] cnt_q;

  assign settled = (cnt_q == LIM);

  always_ff @(posedge clk) begin
    if (clr)                      cnt_q <= '0;
    else if (dclk_en && !settled) cnt_q <= cnt_q + SW'(1);
  end

  a_r9_settle_monotonic: assert property (@(posedge clk) disable iff (clr)
    settled |=> settled);
endmodule

// File: rtl/phase_offset_sched.sv
`timescale 1ns/1ps
module phase_offset_sched
  import pos_pkg::*;
#(
  parameter int OSR_BASE   = 32,
  parameter int SEL_DEF    = 0,
  parameter int SETTLE_CYC = 50
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        hard_rst_n,
  input  logic        dclk_en,
  input  logic        cfg_wr,
  input  logic [7:0]  cfg_phase,
  input  logic [1:0]  cfg_osr_sel,
  output logic        win0,
  output logic        win1,
  output logic        drdy0,
  output logic        drdy1
);
  localparam int CNT_W = $clog2(OSR_BASE) + (1 << SEL_W) - 1;
  localparam int NCH   = 2;

  function automatic logic [CNT_W-1:0] sel_mask(input logic [SEL_W-1:0] s);
    return CNT_W'((OSR_BASE << s) - 1);
  endfunction

  logic       clr;
  sched_cfg_t shadow, active;
  logic [NCH-1:0] hit;
  logic [NCH-1:0] win_q, drdy_q;
  logic       settled;
  logic [CNT_W-1:0] mask_cur, mask_new, load0;
  logic signed [CNT_W+PH_W-1:0] ph_ext, ph_neg;

  assign clr = rst | ~hard_rst_n;

  pos_cfg_regs #(.SEL_DEF(SEL_DEF)) u_cfg (
    .clk(clk), .clr(clr), .wr(cfg_wr),
    .wr_phase(phase_t'(cfg_phase)), .wr_sel(cfg_osr_sel),
    .bnd(hit[1]), .shadow_q(shadow), .active_q(active)
  );

  pos_settle_ctr #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .clr(clr), .dclk_en(dclk_en), .settled(settled)
  );

  // Channel 0 restart offset: -phase modulo the new window length
  always_comb begin
    mask_cur = sel_mask(active.osr_sel);
    mask_new = sel_mask(shadow.osr_sel);
    ph_ext   = {{CNT_W{shadow.phase[PH_W-1]}}, shadow.phase};
    ph_neg   = -ph_ext;
    load0    = ph_neg[CNT_W-1:0] & mask_new;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic             ch_reload;
    logic [CNT_W-1:0] ch_load;
    if (g == 1) begin : g_ref
      assign ch_reload = 1'b0;
      assign ch_load   = '0;
    end else begin : g_shift
      assign ch_reload = hit[1];
      assign ch_load   = load0;
    end
    pos_window_ctr #(.CNT_W(CNT_W)) u_win (
      .clk(clk), .clr(clr), .dclk_en(dclk_en), .mask(mask_cur),
      .reload(ch_reload), .load_val(ch_load), .hit(hit[g])
    );
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      win_q  <= '0;
      drdy_q <= '0;
    end else begin
      win_q  <= hit;
      drdy_q <= hit & {NCH{settled}};
    end
  end

  assign win0  = win_q[0];
  assign win1  = win_q[1];
  assign drdy0 = drdy_q[0];
  assign drdy1 = drdy_q[1];

  a_r7_quiet_in_hold: assert property (@(posedge clk) disable iff (rst)
    !hard_rst_n |=> (win_q == '0 && drdy_q == '0));

  a_r6_strobe_after_enable: assert property (@(posedge clk) disable iff (clr)
    (|win_q) |-> $past(dclk_en));

  a_r9_drdy_has_window: assert property (@(posedge clk) disable iff (clr)
    drdy1 |-> (win1 && $past(settled)));
endmodule

// File: tb/phase_offset_sched_test.sv
`timescale 1ns/1ps
module phase_offset_sched_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, hard_rst_n, dclk_en, cfg_wr;
  logic [7:0] cfg_phase;
  logic [1:0] cfg_osr_sel;
  logic win0, win1, drdy0, drdy1;

  phase_offset_sched uut (
    .clk(clk), .rst(rst), .hard_rst_n(hard_rst_n), .dclk_en(dclk_en),
    .cfg_wr(cfg_wr), .cfg_phase(cfg_phase), .cfg_osr_sel(cfg_osr_sel),
    .win0(win0), .win1(win1), .drdy0(drdy0), .drdy1(drdy1)
  );

  typedef struct { int ch; int idx; string tag; } ev_t;
  ev_t dq[$];
  ev_t wq[$];

  int checks = 0, errors = 0;
  int en_idx = 0, idx_at_edge = 0;
  bit done = 0, en_ph = 0;
  bit rst_v = 1, hr_v = 1, wr_pend = 0;
  logic [7:0] wr_ph = '0;
  logic [1:0] wr_sl = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // driver: one clock per call, inputs change just after the rising edge
  task automatic tick();
    @(posedge clk);
    #2;
    rst = rst_v;
    hard_rst_n = hr_v;
    cfg_wr = wr_pend;
    cfg_phase = wr_ph;
    cfg_osr_sel = wr_sl;
    wr_pend = 0;
    en_ph = ~en_ph;
    dclk_en = en_ph;
    if (rst_v || !hr_v) en_idx = 0;
    else if (en_ph) en_idx++;
  endtask

  task automatic run_until(input int k);
    while (en_idx < k) tick();
  endtask

  task automatic write_cfg(input logic [7:0] ph, input logic [1:0] sl);
    wr_ph = ph; wr_sl = sl; wr_pend = 1;
    tick();
  endtask

  task automatic push_ev(input int ch, input int idx, input bit dr, input string tag);
    ev_t e;
    e.ch = ch; e.idx = idx; e.tag = tag;
    wq.push_back(e);
    if (dr) dq.push_back(e);
  endtask

  task automatic quiet_check(input string tag);
    @(negedge clk);
    chk({win0, win1, drdy0, drdy1} == 4'b0000, tag, "strobes while reset",
        int'({win0, win1, drdy0, drdy1}), 0);
  endtask

  // monitor: pop and compare, one strobe of one clock per scheduled event (R6)
  task automatic observe(input bit seen, input int ch, input bit is_win);
    ev_t e;
    if (!seen) return;
    if (is_win ? (wq.size() == 0) : (dq.size() == 0)) begin
      chk(0, "R6", is_win ? "unscheduled window strobe ch" : "unscheduled data-ready ch",
          ch, -1);
      return;
    end
    e = is_win ? wq.pop_front() : dq.pop_front();
    checks++;
    if (e.ch != ch || e.idx != idx_at_edge) begin
      errors++;
      $display("FAIL %s %s: actual ch%0d at enable %0d, expected ch%0d at enable %0d",
               e.tag, is_win ? "window" : "data-ready", ch, idx_at_edge, e.ch, e.idx);
    end
  endtask

  always @(posedge clk) idx_at_edge <= en_idx;

  always @(negedge clk) begin
    if (!done) begin
      observe(drdy1, 1, 0);
      observe(drdy0, 0, 0);
      observe(win1, 1, 1);
      observe(win0, 0, 1);
    end
  end

  initial begin
    rst = 1; hard_rst_n = 1; dclk_en = 0; cfg_wr = 0; cfg_phase = '0; cfg_osr_sel = '0;
    repeat (6) tick();
    quiet_check("R10");

    // first run, N=32 and phase 0 by default
    push_ev(1, 32, 0, "R9"); push_ev(0, 32, 0, "R9");
    push_ev(1, 64, 1, "R9"); push_ev(0, 64, 1, "R9");
    push_ev(1, 96, 1, "R5"); push_ev(0, 101, 1, "R5");   // +5 applied at 96
    push_ev(1, 128, 1, "R4"); push_ev(0, 133, 1, "R2");
    push_ev(1, 160, 1, "R5"); push_ev(0, 189, 1, "R3");  // -3 applied at 160
    push_ev(1, 192, 1, "R4"); push_ev(0, 221, 1, "R3");
    push_ev(1, 224, 1, "R4"); push_ev(0, 253, 1, "R3");
    push_ev(1, 256, 1, "R5"); push_ev(0, 384, 1, "R1");  // -128, N=256 at 256
    push_ev(1, 512, 1, "R4"); push_ev(0, 640, 1, "R1");
    push_ev(1, 768, 1, "R4"); push_ev(0, 895, 1, "R2");  // +127, N=128 at 768
    push_ev(1, 896, 1, "R4"); push_ev(0, 1023, 1, "R2");
    push_ev(1, 1024, 1, "R4");

    rst_v = 0;
    run_until(70);  write_cfg(8'h05, 2'd0);
    run_until(140); write_cfg(8'hFD, 2'd0);
    run_until(230); write_cfg(8'h80, 2'd3);
    run_until(520); write_cfg(8'h7F, 2'd2);
    run_until(1040);
    chk(wq.size() == 0, "R5", "window events left", wq.size(), 0);
    chk(dq.size() == 0, "R2", "data-ready events left", dq.size(), 0);

    // hard reset with a write that must be ignored
    hr_v = 0;
    tick(); tick();
    write_cfg(8'h0A, 2'd2);
    repeat (10) tick();
    quiet_check("R7");
    push_ev(1, 32, 0, "R9"); push_ev(0, 32, 0, "R8");
    push_ev(1, 64, 1, "R8"); push_ev(0, 64, 1, "R8");
    push_ev(1, 96, 1, "R8"); push_ev(0, 96, 1, "R8");
    hr_v = 1;
    run_until(100);
    repeat (4) tick();
    chk(wq.size() == 0, "R8", "window events left after hold", wq.size(), 0);
    chk(dq.size() == 0, "R9", "data-ready events left after hold", dq.size(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule